// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined arithmetic slice. It first combines operand A with a second operand C to form a pre-sum. Each of the two can be negated, and C can be shifted left by up to 15 places. The slice then multiplies the pre-sum by operand B and adds the product to a running 48-bit accumulator or subtracts it from that accumulator. The operation it performs is `acc = base ± ((±A ± (C << s)) * B)`. The base is normally the accumulator's previous value.

A load control starts a new accumulation. It replaces the base with zero, or with the value on the cascade input when cascade mode is selected. The accumulator register is also driven out on a cascade output. Several slices can therefore be chained, and each slice in the chain contributes one pipeline stage later than the one before it.

The control bits are sampled together with the operands and travel down the pipeline with them, so each operation can use its own settings. The operands pass through a prefilter position that is modelled only as a straight bypass.

Top module: `premac_slice`

## Requirements
- R1: For an accepted operation, the product is (sa·A + sc·(C·2^s))·B. A, B and C are signed two's-complement values, and A and B reach the multiplier unchanged through the bypassed prefilter. A product with B = 0 is zero.
- R2: `neg_a` = 1 gives sa = -1 (otherwise +1). `neg_c` = 1 gives sc = -1 (otherwise +1). The most negative A, when negated, gives its positive magnitude.
- R3: `c_shift` (0 to 15) sets s, so C carries a weight of 2^s relative to A.
- R4: When `sub` = 0 the new accumulator is base + product. When `sub` = 1 it is base - product.
- R5: With `load` = 0 the base is the held accumulator. With `load` = 1 the base is `casc_in` if `casc_sel` = 1, and zero otherwise.
- R6: `out_valid` is high exactly three rising edges after the edge that sampled `in_valid` = 1, and is low otherwise. When no operation completes, the accumulator holds its value.
- R7: The accumulator wraps modulo 2^48. The full-width result is truncated to its low 48 bits.
- R8: `casc_out` always equals the accumulator value presented on `acc_out`.
- R9: A synchronous active-high `rst` clears the accumulator and `out_valid` to zero on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| a_in | input | 18 | Signed operand A |
| b_in | input | 18 | Signed operand B |
| c_in | input | 18 | Signed pre-adder operand C |
| neg_a | input | 1 | Negate A in the pre-adder |
| neg_c | input | 1 | Negate C in the pre-adder |
| c_shift | input | 4 | Left-shift weight applied to C |
| sub | input | 1 | Subtract the product from the base instead of adding it |
| load | input | 1 | Start a new accumulation from a fresh base |
| casc_sel | input | 1 | On load, take the base from casc_in |
| casc_in | input | 48 | Cascade value from the previous slice |
| acc_out | output | 48 | Registered accumulator |
| out_valid | output | 1 | Accumulator updated this cycle |
| casc_out | output | 48 | Accumulator value passed to the next slice |

## Verification
A run of small operations is applied back to back against the same accumulator. Between them the runs cover a positive A, a negated A, a negated C, several shift amounts and both accumulate directions. Each result differs depending on whether the sign, the shift or the direction is honoured, so a wrong sign or a wrong shift shows up as a distinct value. Further operations load from zero and from the cascade input, which tells the two base sources apart. A zero B shows that the product is not leaking into the result. The extreme operands (the most negative A negated, and the full shift with the largest C and B) exercise sign extension and the 48-bit wrap.

// File: rtl/premac_pkg.sv
package premac_pkg;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic               neg_a;
    logic               neg_c;
    logic [SHIFT_W-1:0] c_shift;
    logic               sub;
    logic               load;
    logic               from_casc;
  } op_ctrl_t;
endpackage

// File: rtl/premac_prefilter.sv
module premac_prefilter #(
  parameter int A_W = 18,
  parameter int B_W = 18
) (
  input  logic [A_W-1:0] a_raw,
  input  logic [B_W-1:0] b_raw,
  output logic [A_W-1:0] a_filt,
  output logic [B_W-1:0] b_filt
);
  // Filtering position kept as a straight bypass.
  assign a_filt = a_raw;
  assign b_filt = b_raw;
endmodule

// File: rtl/premac_in_stage.sv
module premac_in_stage
  import premac_pkg::*;
#(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int C_W = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_in,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [C_W-1:0] c_in,
  input  op_ctrl_t       ctrl_in,
  output logic           v_q,
  output logic [A_W-1:0] a_q,
  output logic [B_W-1:0] b_q,
  output logic [C_W-1:0] c_q,
  output op_ctrl_t       ctrl_q
);
  logic [A_W-1:0] a_f;
  logic [B_W-1:0] b_f;

  premac_prefilter #(.A_W(A_W), .B_W(B_W)) u_pf (
    .a_raw(a_in), .b_raw(b_in), .a_filt(a_f), .b_filt(b_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      ctrl_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        a_q    <= a_f;
        b_q    <= b_f;
        c_q    <= c_in;
        ctrl_q <= ctrl_in;
      end
    end
  end

  // R1: operands pass the bypassed prefilter unchanged
  a_r1_bypass_a: assert property (@(posedge clk) disable iff (rst)
    v_in |=> (a_q == $past(a_in)) && (b_q == $past(b_in)));
endmodule

// File: rtl/premac_mult_stage.sv
module premac_mult_stage
  import premac_pkg::*;
#(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int C_W   = 18,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [A_W-1:0]   a,
  input  logic [B_W-1:0]   b,
  input  logic [C_W-1:0]   c,
  input  op_ctrl_t         ctrl_in,
  output logic             v_q,
  output logic [ACC_W-1:0] prod_q,
  output op_ctrl_t         ctrl_q
);
  localparam int MAX_SH = (1 << SHIFT_W) - 1;
  localparam int WIDE   = (A_W > C_W + MAX_SH) ? A_W : C_W + MAX_SH;
  localparam int PS_W   = WIDE + 2;

  generate
    if (ACC_W < PS_W || ACC_W < B_W) begin : g_bad_width
      $error("premac_mult_stage: ACC_W too narrow for the pre-sum");
    end
  endgenerate

  logic signed [PS_W-1:0]  a_ext, c_ext, a_term, c_term, presum;
  logic signed [ACC_W-1:0] ps_wide, b_wide, prod_full;

  always_comb begin
    a_ext   = {{(PS_W-A_W){a[A_W-1]}}, a};
    c_ext   = {{(PS_W-C_W){c[C_W-1]}}, c};
    c_ext   = c_ext <<< ctrl_in.c_shift;
    a_term  = ctrl_in.neg_a ? -a_ext : a_ext;
    c_term  = ctrl_in.neg_c ? -c_ext : c_ext;
    presum  = a_term + c_term;
    ps_wide = {{(ACC_W-PS_W){presum[PS_W-1]}}, presum};
    b_wide  = {{(ACC_W-B_W){b[B_W-1]}}, b};
    prod_full = ps_wide * b_wide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      prod_q <= '0;
      ctrl_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        prod_q <= prod_full;
        ctrl_q <= ctrl_in;
      end
    end
  end

  // R1: a zero multiplier operand yields a zero product
  a_r1_zero_b: assert property (@(posedge clk) disable iff (rst)
    (v_in && b == '0) |=> (prod_q == '0));
  // R3: unshifted, unnegated, zero C: pre-sum is A alone
  a_r3_plain_presum: assert property (@(posedge clk) disable iff (rst)
    (v_in && c == '0 && !ctrl_in.neg_a) |-> (presum == a_ext));
endmodule

// File: rtl/premac_acc_stage.sv
module premac_acc_stage
  import premac_pkg::*;
#(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [ACC_W-1:0] prod,
  input  op_ctrl_t         ctrl_in,
  input  logic [ACC_W-1:0] casc_in,
  output logic [ACC_W-1:0] acc_q,
  output logic             v_q
);
  logic [ACC_W-1:0] base, acc_next;

  always_comb begin
    if (ctrl_in.load) base = ctrl_in.from_casc ? casc_in : '0;
    else              base = acc_q;
    acc_next = ctrl_in.sub ? base - prod : base + prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) acc_q <= acc_next;
    end
  end

  // R6: accumulator holds when nothing completes
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(acc_q));
  // R5: loading zero with a zero product leaves zero
  a_r5_load_zero: assert property (@(posedge clk) disable iff (rst)
    (v_in && ctrl_in.load && !ctrl_in.from_casc && prod == '0) |=> (acc_q == '0));
  // R9: reset clears the state
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !v_q);
endmodule

// File: rtl/premac_slice.sv
module premac_slice
  import premac_pkg::*;
#(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int C_W   = 18,
  parameter int ACC_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [A_W-1:0]     a_in,
  input  logic [B_W-1:0]     b_in,
  input  logic [C_W-1:0]     c_in,
  input  logic               neg_a,
  input  logic               neg_c,
  input  logic [SHIFT_W-1:0] c_shift,
  input  logic               sub,
  input  logic               load,
  input  logic               casc_sel,
  input  logic [ACC_W-1:0]   casc_in,
  output logic [ACC_W-1:0]   acc_out,
  output logic               out_valid,
  output logic [ACC_W-1:0]   casc_out
);
  op_ctrl_t         ctrl_in, ctrl_s1, ctrl_s2;
  logic             v_s1, v_s2;
  logic [A_W-1:0]   a_s1;
  logic [B_W-1:0]   b_s1;
  logic [C_W-1:0]   c_s1;
  logic [ACC_W-1:0] prod_s2, acc_q;

  always_comb begin
    ctrl_in.neg_a     = neg_a;
    ctrl_in.neg_c     = neg_c;
    ctrl_in.c_shift   = c_shift;
    ctrl_in.sub       = sub;
    ctrl_in.load      = load;
    ctrl_in.from_casc = casc_sel;
  end

  premac_in_stage #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_in (
    .clk(clk), .rst(rst), .v_in(in_valid), .a_in(a_in), .b_in(b_in),
    .c_in(c_in), .ctrl_in(ctrl_in), .v_q(v_s1), .a_q(a_s1), .b_q(b_s1),
    .c_q(c_s1), .ctrl_q(ctrl_s1)
  );

  premac_mult_stage #(.A_W(A_W), .B_W(B_W), .C_W(C_W), .ACC_W(ACC_W)) u_mul (
    .clk(clk), .rst(rst), .v_in(v_s1), .a(a_s1), .b(b_s1), .c(c_s1),
    .ctrl_in(ctrl_s1), .v_q(v_s2), .prod_q(prod_s2), .ctrl_q(ctrl_s2)
  );

  premac_acc_stage #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .v_in(v_s2), .prod(prod_s2), .ctrl_in(ctrl_s2),
    .casc_in(casc_in), .acc_q(acc_q), .v_q(out_valid)
  );

  assign acc_out  = acc_q;
  assign casc_out = acc_q;

  // R6: result valid follows the accepted operand by three edges
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    v_s2 |=> out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !v_s2 |=> !out_valid);
endmodule

// File: tb/premac_slice_bench.sv
module premac_slice_bench;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [17:0]        a_in = '0, b_in = '0, c_in = '0;
  logic               neg_a = 1'b0, neg_c = 1'b0, sub = 1'b0, load = 1'b0, casc_sel = 1'b0;
  logic [3:0]         c_shift = '0;
  logic [47:0]        casc_in = '0;
  logic [47:0]        acc_out, casc_out;
  logic               out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  premac_slice u_premac_slice (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .c_in(c_in), .neg_a(neg_a), .neg_c(neg_c), .c_shift(c_shift), .sub(sub),
    .load(load), .casc_sel(casc_sel), .casc_in(casc_in), .acc_out(acc_out),
    .out_valid(out_valid), .casc_out(casc_out)
  );

  // Vector table: a, b, c, shift, neg_a, neg_c, sub, load, expected acc
  localparam int NV = 8;
  localparam int TA  [NV] = '{3, 2, 10, 1, -5, 0, 4, -131072};
  localparam int TB  [NV] = '{4, 5, 3, 7, -6, 100, 0, 1};
  localparam int TC  [NV] = '{0, 1, 2, 1, 0, 1, 9, 0};
  localparam int TS  [NV] = '{0, 2, 0, 1, 0, 15, 0, 0};
  localparam bit TNA [NV] = '{0, 0, 1, 0, 0, 0, 0, 1};
  localparam bit TNC [NV] = '{0, 0, 0, 1, 0, 0, 0, 0};
  localparam bit TSU [NV] = '{0, 0, 0, 1, 0, 0, 0, 1};
  localparam bit TLD [NV] = '{1, 0, 0, 0, 1, 0, 0, 1};
  localparam longint TEXP [NV] = '{12, 42, 18, 25, 30, 3276830, 3276830, -131072};
  localparam string  TREQ [NV] = '{"R1", "R3", "R2", "R4", "R5", "R3", "R1", "R2"};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sx48(input logic [47:0] v);
    return longint'($signed(v));
  endfunction

  // Issue one operation at a falling edge; return at the falling edge after
  // the third rising edge, having checked out_valid low after two edges.
  task automatic issue(input int a, input int b, input int c, input int sh,
                       input bit na, input bit nc, input bit su, input bit ld,
                       input bit cs, input logic [47:0] cin);
    a_in = a[17:0]; b_in = b[17:0]; c_in = c[17:0]; c_shift = sh[3:0];
    neg_a = na; neg_c = nc; sub = su; load = ld; casc_sel = cs; casc_in = cin;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    a_in = 18'h15555; b_in = 18'h2AAAA; c_in = 18'h3FFFF; load = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R6", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6", longint'(out_valid), 1);
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    longint exp, cur;
    logic [47:0] hold;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(acc_out == '0, "R9", sx48(acc_out), 0);
    check(out_valid == 1'b0, "R9", longint'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(TA[i], TB[i], TC[i], TS[i], TNA[i], TNC[i], TSU[i], TLD[i], 1'b0, '0);
      check(sx48(acc_out) == TEXP[i], TREQ[i], sx48(acc_out), TEXP[i]);
      check(casc_out == acc_out, "R8", sx48(casc_out), sx48(acc_out));
    end

    // R6: accumulator holds while idle, despite garbage on operand inputs
    hold = acc_out;
    repeat (4) @(negedge clk);
    check(acc_out == hold && !out_valid, "R6", sx48(acc_out), sx48(hold));

    // R5: load from cascade input, add then subtract
    issue(2, 3, 0, 0, 0, 0, 0, 1, 1, 48'd1000);
    check(sx48(acc_out) == 1006, "R5", sx48(acc_out), 1006);
    issue(2, 3, 0, 0, 0, 0, 1, 1, 1, 48'd1000);
    check(sx48(acc_out) == 994, "R5", sx48(acc_out), 994);
    // R5: cascade input ignored when not loading
    issue(1, 1, 0, 0, 0, 0, 0, 0, 1, 48'd77777);
    check(sx48(acc_out) == 995, "R5", sx48(acc_out), 995);

    // R7: wrap with largest pre-sum and most negative B
    cur = (longint'(131071) + (longint'(131071) <<< 15)) * longint'(-131072);
    exp = sx48(cur[47:0]);
    issue(131071, -131072, 131071, 15, 0, 0, 0, 1, 0, '0);
    check(sx48(acc_out) == exp, "R7", sx48(acc_out), exp);
    cur = cur + cur;
    exp = sx48(cur[47:0]);
    issue(131071, -131072, 131071, 15, 0, 0, 0, 0, 0, '0);
    check(sx48(acc_out) == exp, "R7", sx48(acc_out), exp);
    check(casc_out == acc_out, "R8", sx48(casc_out), sx48(acc_out));

    // R2: both negations together: (-6 - 8) * 2 = -28
    issue(6, 2, 1, 3, 1, 1, 0, 1, 0, '0);
    check(sx48(acc_out) == -28, "R2", sx48(acc_out), -28);

    // R9: synchronous reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check(acc_out == '0 && !out_valid, "R9", sx48(acc_out), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule